// File: doc/BRIEF.md
# Multiplexed External Memory Bus Interface

This block moves single bytes between a processor core and external memory over two 8-bit ports. One port is shared by address and data. It carries the low address byte first and then the data byte. A strobe tells an external latch when to capture the low address. The second port carries the high address byte for the whole transfer. Three kinds of transfer are supported:

- a code fetch, which takes its address from the program counter input;
- a data read, which takes its address from the data pointer input;
- a data write, which also takes its address from the data pointer input.

Each transfer has a fixed sequence of four parts:

1. An address phase of `ADDR_CYC` cycles.
2. A one-cycle latch hold.
3. A strobe phase of `STRB_CYC` cycles.
4. One closing cycle.

Requests enter through a valid/ready handshake. `req_ready` is the inverse of `busy`. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While a transfer runs, `req_ready` is low. Any request presented during that time has no effect. The requester keeps `req_valid` high, and the request is taken in the first cycle where `req_ready` returns.

Read results leave as a one-cycle `rsp_valid` pulse with `rsp_data`. There is no back-pressure on that output, so the consumer must take the byte in the cycle it is offered.

The shared port is modelled as separate `ad_out` and `ad_in` lines plus an enable, `ad_oe`. The pad ring builds the three-state buffer from these.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is low, and after reset is released with no request, the outputs take these values: `busy`=0, `req_ready`=1, `ale`=0, `ad_oe`=0, `ad_out`=0, `hi_addr`=0, `rsp_valid`=0, and all three strobes (`code_rd_n`, `rd_n`, `wr_n`) high.
- R2: A request is accepted on a clock edge where `req_valid`=1, `req_ready`=1 and `req_kind` is 0, 1 or 2. From the next cycle, `busy` is high for exactly ADDR_CYC+STRB_CYC+2 cycles. `req_ready` is always the inverse of `busy`.
- R3: Kind 0 (code fetch) takes its address from `pc_addr`. Kinds 1 (data read) and 2 (data write) take it from `dp_addr`. The address is captured at acceptance, and later changes on either input do not affect the running transfer. `hi_addr` shows the captured high byte in every busy cycle and is 0 when idle.
- R4: During the first ADDR_CYC busy cycles, `ale`=1, `ad_oe`=1 and `ad_out` equals the captured low address byte.
- R5: In the busy cycle right after the address phase, `ale` is 0 while `ad_oe` stays 1 and `ad_out` still holds the low address byte.
- R6: For reads, the next STRB_CYC cycles form the strobe phase. In that phase `ad_oe`=0 and `ad_out`=0. `code_rd_n` is low for kind 0, and `rd_n` is low for kind 1. No other strobe goes low.
- R7: For a write, `wr_n` is low for the STRB_CYC cycles of the strobe phase. `ad_oe`=1 and `ad_out` equals `wr_byte` as captured at acceptance, through the strobe phase and the closing cycle.
- R8: A read returns the `ad_in` value present at the clock edge where its strobe rises. `rsp_valid` is high for the single closing cycle of each read and never for a write. `rsp_data` holds the last read byte until the next read completes.
- R9: A request with `req_kind`=3 is ignored: `busy` stays low. A request presented while `busy` is high is also ignored, and the running transfer continues unchanged.
- R10: If `req_valid` is held high with a valid kind, exactly one idle cycle (`busy`=0) separates consecutive transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (the inverse of `busy`) |
| req_kind | input | 2 | Transfer kind: 0 = code fetch, 1 = data read, 2 = data write, 3 = none |
| pc_addr | input | 16 | Program counter address, used for code fetches |
| dp_addr | input | 16 | Data pointer address, used for data transfers |
| wr_byte | input | 8 | Byte to write |
| busy | output | 1 | A transfer is in progress |
| rsp_valid | output | 1 | Read byte available (one-cycle pulse) |
| rsp_data | output | 8 | Last byte read |
| ad_out | output | 8 | Shared port, outgoing address or data |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | 8 | Shared port, incoming data |
| hi_addr | output | 8 | High address byte port |
| ale | output | 1 | Address latch strobe, active high |
| code_rd_n | output | 1 | Code fetch read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
Two events can fall in the same cycle:

- the closing cycle of a transfer, which raises `rsp_valid`;
- a new request presented while `busy` is still high.

The bench provokes this overlap by holding `req_valid` high through whole transfers, by driving random request patterns, and by changing `pc_addr` and `dp_addr` on every cycle. A behavioural model compares every cycle and checks three things:

- the late request neither shortens nor disturbs the running transfer;
- the request is taken only after the single idle cycle;
- the response byte comes from the `ad_in` value at the strobe's rising edge, although `ad_in` changes every cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    K_CODE = 2'd0,
    K_DRD  = 2'd1,
    K_DWR  = 2'd2,
    K_NONE = 2'd3
  } xfer_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_LATCH = 3'd2,
    PH_DATA  = 3'd3,
    PH_END   = 3'd4
  } phase_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_CYC = 2,
  parameter int STRB_CYC = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   data_last
);
  localparam int MAXC = (ADDR_CYC > STRB_CYC) ? ADDR_CYC : STRB_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] A_LAST = CW'(ADDR_CYC - 1);
  localparam logic [CW-1:0] S_LAST = CW'(STRB_CYC - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q + 1'b1;
    case (ph_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start) ph_d = PH_ADDR;
      end
      PH_ADDR: begin
        if (cnt_q == A_LAST) begin
          ph_d  = PH_LATCH;
          cnt_d = '0;
        end
      end
      PH_LATCH: begin
        ph_d  = PH_DATA;
        cnt_d = '0;
      end
      PH_DATA: begin
        if (cnt_q == S_LAST) begin
          ph_d  = PH_END;
          cnt_d = '0;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase     = ph_q;
  assign data_last = (ph_q == PH_DATA) && (cnt_q == S_LAST);

  // R4: the address phase never runs past its configured length
  p_addr_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ADDR) |-> (cnt_q <= A_LAST));
  // R6: the strobe phase never runs past its configured length
  p_strb_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA) |-> (cnt_q <= S_LAST));
endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  xfer_kind_e  kind_in,
  input  logic [15:0] pc_addr,
  input  logic [15:0] dp_addr,
  input  logic [7:0]  wr_byte,
  input  phase_e      phase,
  input  logic        data_last,
  input  logic [7:0]  ad_in,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  hi_addr,
  output logic        ale,
  output logic        code_rd_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data
);
  xfer_kind_e  kind_q;
  logic [15:0] addr_q;
  logic [7:0]  wbyte_q;
  logic [7:0]  rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_CODE;
      addr_q  <= '0;
      wbyte_q <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        kind_q  <= kind_in;
        addr_q  <= (kind_in == K_CODE) ? pc_addr : dp_addr;
        wbyte_q <= wr_byte;
      end
      if (data_last && (kind_q != K_DWR)) rdata_q <= ad_in;
    end
  end

  logic active, addr_ph, is_wr, wr_drive, strobe;

  always_comb begin
    active    = (phase != PH_IDLE);
    addr_ph   = (phase == PH_ADDR) || (phase == PH_LATCH);
    is_wr     = (kind_q == K_DWR);
    wr_drive  = is_wr && ((phase == PH_DATA) || (phase == PH_END));
    strobe    = (phase == PH_DATA);
    ale       = (phase == PH_ADDR);
    ad_oe     = addr_ph || wr_drive;
    ad_out    = addr_ph ? addr_q[7:0] : (wr_drive ? wbyte_q : 8'h00);
    hi_addr   = active ? addr_q[15:8] : 8'h00;
    code_rd_n = !(strobe && (kind_q == K_CODE));
    rd_n      = !(strobe && (kind_q == K_DRD));
    wr_n      = !(strobe && is_wr);
    rsp_valid = (phase == PH_END) && !is_wr;
  end

  assign rsp_data = rdata_q;

  // R5: when the latch strobe falls the low address is still driven and unchanged
  p_ale_fall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && $stable(ad_out)));
  // R6: at most one strobe is active at a time
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~code_rd_n, ~rd_n, ~wr_n}) <= 1);
  // R6: the shared port is released whenever a read strobe is low
  p_rd_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_rd_n || !rd_n) |-> !ad_oe);
  // R8: a response follows the rising edge of a read strobe
  p_rsp_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($rose(code_rd_n) || $rose(rd_n)));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_CYC = 2,
  parameter int STRB_CYC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [15:0] pc_addr,
  input  logic [15:0] dp_addr,
  input  logic [7:0]  wr_byte,
  output logic        busy,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in,
  output logic [7:0]  hi_addr,
  output logic        ale,
  output logic        code_rd_n,
  output logic        rd_n,
  output logic        wr_n
);
  xfer_kind_e kind;
  phase_e     phase;
  logic       data_last;
  logic       start;

  assign kind      = xfer_kind_e'(req_kind);
  assign busy      = (phase != PH_IDLE);
  assign req_ready = !busy;
  assign start     = req_valid && req_ready && (kind != K_NONE);

  xbus_seq #(.ADDR_CYC(ADDR_CYC), .STRB_CYC(STRB_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .phase     (phase),
    .data_last (data_last)
  );

  xbus_dpath u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .kind_in   (kind),
    .pc_addr   (pc_addr),
    .dp_addr   (dp_addr),
    .wr_byte   (wr_byte),
    .phase     (phase),
    .data_last (data_last),
    .ad_in     (ad_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .hi_addr   (hi_addr),
    .ale       (ale),
    .code_rd_n (code_rd_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // R2: a transfer only begins after an offered request of a valid kind
  p_start_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req_valid) && ($past(req_kind) != 2'd3)));
  // R9: the high address byte stays put for the whole transfer
  p_hi_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(hi_addr));
  // R1: idle bus is quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ad_oe && !ale && code_rd_n && rd_n && wr_n && !rsp_valid));
endmodule

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
  localparam int A = 2;
  localparam int S = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] pc_addr = '0;
  logic [15:0] dp_addr = '0;
  logic [7:0]  wr_byte = '0;
  logic [7:0]  ad_in = '0;
  logic        req_ready, busy, rsp_valid, ad_oe, ale, code_rd_n, rd_n, wr_n;
  logic [7:0]  rsp_data, ad_out, hi_addr;

  always #10 clk = ~clk;

  xbus_ctrl #(.ADDR_CYC(A), .STRB_CYC(S)) i_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .pc_addr(pc_addr), .dp_addr(dp_addr), .wr_byte(wr_byte),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .hi_addr(hi_addr), .ale(ale),
    .code_rd_n(code_rd_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference
  bit        m_act = 1'b0;
  int        m_t = 0;
  int        m_kind = 0;
  bit [15:0] m_addr = '0;
  bit [7:0]  m_wb = '0;
  bit [7:0]  m_rd = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_t = 0; m_kind = 0; m_addr = 0; m_wb = 0; m_rd = 0;
    end else begin
      cyc++;
      if (m_act) begin
        if (m_t == A + S && m_kind != 2) m_rd = ad_in;
        if (m_t == A + S + 1) m_act = 0;
        else m_t++;
      end else if (req_valid && req_kind != 2'd3) begin
        m_act = 1; m_t = 0; m_kind = int'(req_kind);
        m_addr = (req_kind == 2'd0) ? pc_addr : dp_addr;
        m_wb = wr_byte;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      bit in_addr, in_data, in_end, wr;
      in_addr = m_act && (m_t <= A);
      in_data = m_act && (m_t > A) && (m_t <= A + S);
      in_end  = m_act && (m_t == A + S + 1);
      wr      = (m_kind == 2);
      chk("R2 busy", 16'(busy), 16'(m_act));
      chk("R2 req_ready", 16'(req_ready), 16'(!m_act));
      chk("R3 hi_addr", 16'(hi_addr), m_act ? 16'(m_addr[15:8]) : 16'h0);
      chk("R4 ale", 16'(ale), 16'(m_act && m_t < A));
      chk("R5/R6 ad_oe", 16'(ad_oe), 16'(in_addr || (wr && (in_data || in_end))));
      chk(wr ? "R7 ad_out" : "R4 ad_out", 16'(ad_out),
          in_addr ? 16'(m_addr[7:0]) : ((wr && (in_data || in_end)) ? 16'(m_wb) : 16'h0));
      chk("R6 code_rd_n", 16'(code_rd_n), 16'(!(in_data && m_kind == 0)));
      chk("R6 rd_n", 16'(rd_n), 16'(!(in_data && m_kind == 1)));
      chk("R7 wr_n", 16'(wr_n), 16'(!(in_data && wr)));
      chk("R8 rsp_valid", 16'(rsp_valid), 16'(in_end && !wr));
      chk("R8 rsp_data", 16'(rsp_data), 16'(m_rd));
    end
  end

  // shared-port input changes every cycle so the sampling instant matters
  always @(negedge clk) ad_in <= 8'(cyc * 37 + 11);

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 busy in reset", 16'(busy), 16'h0);
    chk("R1 ale in reset", 16'(ale), 16'h0);
    chk("R1 strobes in reset", 16'({code_rd_n, rd_n, wr_n}), 16'h7);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    chk("R1 ad_oe idle", 16'(ad_oe), 16'h0);
    chk("R1 hi_addr idle", 16'(hi_addr), 16'h0);
    // R9: kind 3 is ignored
    req_valid = 1'b1; req_kind = 2'd3; dp_addr = 16'hBEEF;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9 kind 3 leaves busy low", 16'(busy), 16'h0);
    // R10: held request, back-to-back transfers
    req_valid = 1'b1; req_kind = 2'd1; dp_addr = 16'h1234; wr_byte = 8'h5A;
    @(negedge clk);
    chk("R10 first accepted", 16'(busy), 16'h1);
    while (busy) @(negedge clk);
    chk("R10 one idle cycle", 16'(busy), 16'h0);
    @(negedge clk);
    chk("R10 next accepted after one idle cycle", 16'(busy), 16'h1);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    // random traffic with addresses changing every cycle
    for (int i = 0; i < 4000; i++) begin
      req_valid = ($urandom % 4) != 0;
      req_kind  = 2'($urandom % 4);
      pc_addr   = 16'($urandom);
      dp_addr   = 16'($urandom);
      wr_byte   = 8'($urandom);
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule